// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block drives one half of an H-bridge from a single PWM channel. A period counter runs from zero up to the programmed period minus one, and a raw level is asserted while the count is below the programmed duty. The high-side output follows the raw level. The low-side output follows its complement. Each output has its own programmable delay. The delay holds back only the turn-on edge of that output, so the two switches are never conducting together. No delay ever makes an output stay on longer.

Software programs the block through a plain write port: a write strobe, an address and a data word. Period and duty are 16 bits. Each delay is 12 bits and counts in clock cycles. While the channel runs, new timing values go to holding registers, and all of them take effect together at the next counter wrap. While the channel is stopped, a write takes effect at once. Each delay is checked against the phase it sits in. A value that does not fit is forced to zero.

Top module: `pwm_deadband_pair`

## Requirements
- R1: After reset the channel is stopped, `ch_enabled` is 0, polarity is 0, and both pins sit at their inactive level, which is 1.
- R2: Address 0 is the control word: bit 0 runs the channel, bit 1 enables dead-time insertion, and bit 2 is the polarity. `ch_enabled` shows bit 0 from the cycle after the write.
- R3: While running, the counter steps 0..P-1 and then wraps to 0; a period of 0 or 1 wraps every cycle. The raw level is 1 while count < duty. The high side tracks the raw level and the low side tracks its complement, both one clock after the count. Address 1 is the period and address 2 is the duty.
- R4: The high-side delay (address 3, low 12 bits) holds back the high-side turn-on by that many clocks. The turn-off stays where it would be without the delay.
- R5: The low-side delay (address 4, low 12 bits) holds back the low-side turn-on by that many clocks. The turn-off stays where it would be without the delay.
- R6: A high-side delay of P-duty or more is used as 0. A low-side delay of duty or more is used as 0.
- R7: With control bit 1 clear, both delays are ignored. The outputs then follow the raw level and its complement directly.
- R8: While running, writes to addresses 1..4 are held and copied into use at the next counter wrap. A write in the same cycle as the wrap waits for the following wrap. While stopped, these writes apply at once.
- R9: While stopped, both pins are at their inactive level and the counter is held at 0. Counting restarts from 0 when the channel is started again.
- R10: An active output drives its pin to the polarity bit value. An inactive output drives the inverse of that value.
- R11: The high side and the low side are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| out_hi | output | 1 | High-side switch drive |
| out_lo | output | 1 | Low-side switch drive |
| ch_enabled | output | 1 | Channel running status |

## Verification
The hardest case to reach from the ports is a timing write that lands in the very cycle the counter wraps, together with a delay set exactly at its phase limit. Reaching it needs the write cycle to line up with the period length. The bench therefore runs many short periods and issues random writes at random cycles, so such collisions happen often. Directed steps add values at the limit and just under it. A cycle-level model in the bench predicts both pins on every cycle.

// File: rtl/pwm_db_pkg.sv
package pwm_db_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL    = 3'd0,
        REG_PERIOD  = 3'd1,
        REG_DUTY    = 3'd2,
        REG_DEAD_HI = 3'd3,
        REG_DEAD_LO = 3'd4
    } reg_addr_e;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_DTEN_BIT = 1;
    localparam int CTRL_POL_BIT  = 2;
endpackage

// File: rtl/pwm_db_regs.sv
module pwm_db_regs
    import pwm_db_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              wrap,
    output logic              run,
    output logic              dten,
    output logic              pol,
    output logic [CNT_W-1:0]  per,
    output logic [CNT_W-1:0]  duty,
    output logic [DT_W-1:0]   dth,
    output logic [DT_W-1:0]   dtl
);
    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] duty;
        logic [DT_W-1:0]  dth;
        logic [DT_W-1:0]  dtl;
    } timing_t;

    typedef struct packed {
        logic    run;
        logic    dten;
        logic    pol;
        timing_t shd;
        timing_t act;
    } state_t;

    state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        // Held values enter use only at a wrap of a running counter
        if (st_q.run && wrap) st_d.act = st_q.shd;
        if (wr_en) begin
            case (wr_addr)
                REG_CTRL: begin
                    st_d.run  = wr_data[CTRL_RUN_BIT];
                    st_d.dten = wr_data[CTRL_DTEN_BIT];
                    st_d.pol  = wr_data[CTRL_POL_BIT];
                end
                REG_PERIOD: begin
                    st_d.shd.per = wr_data;
                    if (!st_q.run) st_d.act.per = wr_data;
                end
                REG_DUTY: begin
                    st_d.shd.duty = wr_data;
                    if (!st_q.run) st_d.act.duty = wr_data;
                end
                REG_DEAD_HI: begin
                    st_d.shd.dth = wr_data[DT_W-1:0];
                    if (!st_q.run) st_d.act.dth = wr_data[DT_W-1:0];
                end
                REG_DEAD_LO: begin
                    st_d.shd.dtl = wr_data[DT_W-1:0];
                    if (!st_q.run) st_d.act.dtl = wr_data[DT_W-1:0];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run  = st_q.run;
    assign dten = st_q.dten;
    assign pol  = st_q.pol;
    assign per  = st_q.act.per;
    assign duty = st_q.act.duty;
    assign dth  = st_q.act.dth;
    assign dtl  = st_q.act.dtl;
endmodule

// File: rtl/pwm_db_timebase.sv
module pwm_db_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] duty,
    output logic             wrap,
    output logic             raw
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] last;

    always_comb begin
        last = (per == '0) ? '0 : per - 1'b1;
        wrap = run && (cnt_q >= last);
        raw  = cnt_q < duty;
        if (!run)      cnt_d = '0;
        else if (wrap) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pwm_db_delay.sv
module pwm_db_delay #(
    parameter int DT_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            want,
    input  logic [DT_W-1:0] dly,
    output logic            act
);
    typedef struct packed {
        logic            want;
        logic [DT_W-1:0] cnt;
        logic            act;
    } dstate_t;

    dstate_t s_q, s_d;

    always_comb begin
        s_d      = s_q;
        s_d.want = want;
        if (!want) begin
            s_d.cnt = '0;
            s_d.act = 1'b0;
        end else if (!s_q.want) begin
            // Turn-on request: load the delay, go active at once only if zero
            s_d.cnt = dly;
            s_d.act = (dly == '0);
        end else if (s_q.cnt > 1) begin
            s_d.cnt = s_q.cnt - 1'b1;
            s_d.act = 1'b0;
        end else begin
            s_d.cnt = '0;
            s_d.act = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act = s_q.act;
endmodule

// File: rtl/pwm_deadband_pair.sv
module pwm_deadband_pair
    import pwm_db_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              out_hi,
    output logic              out_lo,
    output logic              ch_enabled
);
    localparam int SIDES = 2;

    logic             run, dten, pol, wrap, raw_lvl;
    logic [CNT_W-1:0] per, duty;
    logic [DT_W-1:0]  dth, dtl;
    logic [CNT_W:0]   hi_room;
    logic             hi_fits, lo_fits;
    logic [SIDES-1:0] want, side_act;
    logic [DT_W-1:0]  dly [SIDES];
    logic             act_hi, act_lo;

    pwm_db_regs #(.CNT_W(CNT_W), .DT_W(DT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wrap(wrap), .run(run), .dten(dten), .pol(pol),
        .per(per), .duty(duty), .dth(dth), .dtl(dtl)
    );

    pwm_db_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .run(run), .per(per), .duty(duty),
        .wrap(wrap), .raw(raw_lvl)
    );

    // Each delay must fit inside the phase it delays
    always_comb begin
        hi_room = {1'b0, per} - {1'b0, duty};
        hi_fits = !hi_room[CNT_W] &&
                  ({{(CNT_W+1-DT_W){1'b0}}, dth} < hi_room);
        lo_fits = {{(CNT_W-DT_W){1'b0}}, dtl} < duty;
        dly[0]  = (dten && hi_fits) ? dth : '0;
        dly[1]  = (dten && lo_fits) ? dtl : '0;
        want[0] = run && raw_lvl;
        want[1] = run && !raw_lvl;
    end

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        pwm_db_delay #(.DT_W(DT_W)) u_dly (
            .clk(clk), .rst_n(rst_n), .want(want[s]), .dly(dly[s]),
            .act(side_act[s])
        );
    end

    assign act_hi     = run && side_act[0];
    assign act_lo     = run && side_act[1];
    assign out_hi     = act_hi ? pol : !pol;
    assign out_lo     = act_lo ? pol : !pol;
    assign ch_enabled = run;
endmodule

// File: rtl/pwm_db_checker.sv
module pwm_db_checker
    import pwm_db_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              out_hi,
    input logic              out_lo,
    input logic              ch_enabled,
    input logic              pol,
    input logic              act_hi,
    input logic              act_lo,
    input logic              raw_lvl
);
    p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(act_hi && act_lo));

    p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_enabled |-> (out_hi == !pol && out_lo == !pol));

    p_status_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == REG_CTRL) |=> ch_enabled == $past(wr_data[CTRL_RUN_BIT]));

    p_no_extend_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act_hi |-> $past(ch_enabled && raw_lvl));

    p_no_extend_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_lo |-> $past(ch_enabled && !raw_lvl));
endmodule

bind pwm_deadband_pair pwm_db_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .out_hi(out_hi), .out_lo(out_lo),
    .ch_enabled(ch_enabled), .pol(pol), .act_hi(act_hi), .act_lo(act_lo),
    .raw_lvl(raw_lvl)
);

// File: tb/pwm_deadband_pair_tb.sv
module pwm_deadband_pair_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        out_hi, out_lo, ch_enabled;

    always #10 clk = ~clk;

    pwm_deadband_pair u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_hi(out_hi), .out_lo(out_lo),
        .ch_enabled(ch_enabled)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    // Reference model state, built from the requirements
    bit m_run, m_dten, m_pol, on_a, on_b;
    int s_per, s_duty, s_dth, s_dtl, a_per, a_duty, a_dth, a_dtl;
    int m_cnt, run_a, run_b, d_a, d_b;

    function automatic int eff_hi();
        if (!m_dten) return 0;
        return (a_dth >= a_per - a_duty) ? 0 : a_dth;
    endfunction

    function automatic int eff_lo();
        if (!m_dten) return 0;
        return (a_dtl >= a_duty) ? 0 : a_dtl;
    endfunction

    function automatic logic pin_of(bit on);
        return on ? m_pol : !m_pol;
    endfunction

    always @(posedge clk) begin
        bit raw, wa, wb, wrap, old_run;
        int last;
        if (!rst_n) begin
            m_run = 0; m_dten = 0; m_pol = 0; on_a = 0; on_b = 0;
            s_per = 0; s_duty = 0; s_dth = 0; s_dtl = 0;
            a_per = 0; a_duty = 0; a_dth = 0; a_dtl = 0;
            m_cnt = 0; run_a = 0; run_b = 0; d_a = 0; d_b = 0;
        end else begin
            raw = m_cnt < a_duty;
            wa  = m_run && raw;
            wb  = m_run && !raw;
            if (!wa) begin run_a = 0; on_a = 0; end
            else begin
                if (run_a == 0) d_a = eff_hi();
                if (run_a < 1000000) run_a++;
                on_a = run_a > d_a;
            end
            if (!wb) begin run_b = 0; on_b = 0; end
            else begin
                if (run_b == 0) d_b = eff_lo();
                if (run_b < 1000000) run_b++;
                on_b = run_b > d_b;
            end
            old_run = m_run;
            last = (a_per == 0) ? 0 : a_per - 1;
            wrap = m_run && (m_cnt >= last);
            if (!m_run) m_cnt = 0;
            else if (wrap) begin
                m_cnt = 0;
                a_per = s_per; a_duty = s_duty; a_dth = s_dth; a_dtl = s_dtl;
            end else m_cnt++;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin m_run = wr_data[0]; m_dten = wr_data[1]; m_pol = wr_data[2]; end
                    3'd1: begin s_per = wr_data; if (!old_run) a_per = wr_data; end
                    3'd2: begin s_duty = wr_data; if (!old_run) a_duty = wr_data; end
                    3'd3: begin s_dth = wr_data & 16'h0fff; if (!old_run) a_dth = s_dth; end
                    3'd4: begin s_dtl = wr_data & 16'h0fff; if (!old_run) a_dtl = s_dtl; end
                    default: ;
                endcase
            end
        end
    end

    task automatic check_bit(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Every cycle: pins and status against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check_bit(cur_req, "out_hi", out_hi, pin_of(m_run && on_a));
            check_bit(cur_req, "out_lo", out_lo, pin_of(m_run && on_b));
            check_bit(cur_req, "ch_enabled", ch_enabled, m_run);
            // R11: never both pins at the active level while running
            if (m_run)
                check_bit("R11", "both_active", (out_hi == m_pol) && (out_lo == m_pol), 1'b0);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ctrl word: bit0 run, bit1 dead-time enable, bit2 polarity
    function automatic int ctl(bit r, bit dt, bit p);
        return int'(r) | (int'(dt) << 1) | (int'(p) << 2);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check_bit("R1", "reset out_hi", out_hi, 1'b1);
        check_bit("R1", "reset out_lo", out_lo, 1'b1);
        check_bit("R1", "reset ch_enabled", ch_enabled, 1'b0);
        idle(3);

        cur_req = "R3";
        wr(1, 10); wr(2, 4);
        cur_req = "R2";
        wr(0, ctl(1, 0, 1));
        check_bit("R2", "status after start", ch_enabled, 1'b1);
        cur_req = "R3";
        idle(35);
        wr(1, 1); idle(6);                 // R3: period 1 wraps every cycle
        wr(1, 0); idle(6);
        wr(0, 0); wr(1, 10); wr(2, 4);

        cur_req = "R4";
        wr(3, 2); wr(4, 0); wr(0, ctl(1, 1, 1)); idle(35);
        wr(0, 0);
        cur_req = "R5";
        wr(3, 0); wr(4, 3); wr(0, ctl(1, 1, 1)); idle(35);
        wr(0, 0);

        cur_req = "R6";
        wr(3, 6); wr(4, 4); wr(0, ctl(1, 1, 1)); idle(25);   // both at limit
        wr(0, 0);
        wr(3, 5); wr(4, 3); wr(0, ctl(1, 1, 1)); idle(25);   // just under
        wr(0, 0);
        wr(2, 12); wr(3, 1); wr(4, 2); wr(0, ctl(1, 1, 1)); idle(25);
        wr(0, 0); wr(2, 4);

        cur_req = "R7";
        wr(3, 3); wr(4, 2); wr(0, ctl(1, 0, 1)); idle(25);

        cur_req = "R8";
        idle(3); wr(2, 7); idle(4); wr(1, 14); wr(3, 2); idle(40);
        cur_req = "R9";
        wr(0, ctl(0, 1, 1)); idle(8); wr(2, 5); idle(3);
        wr(0, ctl(1, 1, 1)); idle(20);

        cur_req = "R10";
        wr(0, ctl(1, 1, 0)); idle(30);

        cur_req = "R8";
        for (int it = 0; it < 60; it++) begin
            int k;
            k = int'($urandom % 8);
            case (k)
                0, 1: wr(1, int'($urandom % 20));
                2, 3: wr(2, int'($urandom % 24));
                4:    wr(3, int'($urandom % 14));
                5:    wr(4, int'($urandom % 14));
                6:    wr(0, ctl(($urandom % 4) != 0, $urandom % 2 == 1, $urandom % 2 == 1));
                default: ;
            endcase
            idle(int'($urandom % 30));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule